// File: doc/BRIEF.md
# NMI Latch and Wakeup Interrupt Controller

This block sits in an always-on power domain. It collects interrupt and wake sources for a processor that may be asleep. A single non-maskable pad input goes through a programmable trigger stage into a set/reset latch. The latch output is driven out as a level-high interrupt. The level stays high until software acknowledges it, whatever the trigger type of the pad.

Besides the pad, the block gathers two kinds of wake source into a 64-bit pending vector:
- Direct sources each own one pending bit.
- Muxed sources are qualified one by one by a mux-enable vector, then OR-ed eight at a time into a shared pending bit.

A per-bit enable vector selects which pending bits can raise the wakeup request. All state is reached through a small byte-addressed register port. Read data returns one cycle after the read strobe.

Top module: `nmi_wake_ctrl`

## Requirements
- R1: After reset, every pending bit is 0 and only enable bit 0 is 1. All mux-enable bits are 0, the trigger mode reads 2 (level high), and `nmi_irq` and `wake_req` are 0.
- R2: The trigger mode is bits [1:0] of offset 0x0C. The codes are 0 = level low, 1 = falling edge, 2 = level high, 3 = rising edge. Pending bit 0 is set at the first clock edge that samples the selected condition on `nmi_pad`. Edges are judged against the previous clock's sample of the pad.
- R3: Once set, pending bit 0 stays set after the pad goes inactive. Writing 1 to bit 0 at offset 0x10 clears it. Writing 0 to that bit leaves it unchanged.
- R4: In level mode, an acknowledge made while the pad is still active clears bit 0 at the write edge. The bit sets again at the next clock edge.
- R5: `nmi_irq` equals pending bit 0 after every edge, in every trigger mode, and does not depend on enable bit 0.
- R6: `src_direct[k]` being high at a clock edge sets pending bit k+1, for k = 0..17. The bit then holds until it is cleared by a write of 1.
- R7: Muxed source m sets pending bit 19 + m/8 only while its mux-enable bit is 1. Mux-enable bit m sits at offset 0xC0 + 4*(m/32), bit m%32. With its mux-enable bit at 0, the source has no effect.
- R8: Writes to pending words (0x10 for bits 0..31, 0x14 for bits 32..63) clear exactly the bits written with 1. A clear takes priority over a set arriving in the same cycle.
- R9: `wake_req` rises one clock after any pending bit with its enable bit set exists. It falls one clock after no such bit exists. Enable words are at 0x40 and 0x44.
- R10: `bus_rdata` holds the addressed word one clock after `bus_rd`. Unmapped offsets read 0. Pending bits 35..63 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| nmi_pad | input | 1 | Non-maskable pad input |
| src_direct | input | 18 | Direct wake sources, bit k feeds pending bit k+1 |
| mux_src | input | 128 | Muxed wake sources |
| nmi_irq | output | 1 | Latched level-high NMI |
| wake_req | output | 1 | Registered wakeup request |

## Verification
The hard case is a write-one-to-clear acknowledge and a new set of the same pending bit in one cycle. This can happen to the NMI latch in level mode and to any direct source. The bench provokes it by driving the clearing write and the active source on the same clock. For the NMI it then checks `nmi_irq` low right after the write edge and high again one edge later. For a direct source it pulses the source only during the write cycle and reads the pending word back as cleared. It also holds the source on and reads the bit back as set again.

// File: rtl/nmi_wake_pkg.sv
package nmi_wake_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_e;

  localparam trig_e      TRIG_RESET = TRIG_LVL_HI;
  localparam logic [7:0] OFS_TRIG   = 8'h0C;
  localparam logic [7:0] OFS_PEND   = 8'h10;
  localparam logic [7:0] OFS_EN     = 8'h40;
  localparam logic [7:0] OFS_MUXEN  = 8'hC0;
endpackage

// File: rtl/nmi_trigger.sv
module nmi_trigger
  import nmi_wake_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pad,
  input  trig_e mode,
  output logic  hit
);
  logic pad_q;

  always_ff @(posedge clk) begin
    if (rst) pad_q <= 1'b0;
    else     pad_q <= pad;
  end

  always_comb begin
    unique case (mode)
      TRIG_LVL_LO: hit = ~pad;
      TRIG_FALL:   hit = pad_q & ~pad;
      TRIG_LVL_HI: hit = pad;
      TRIG_RISE:   hit = ~pad_q & pad;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/mux_gather.sv
module mux_gather #(
  parameter int MUX_BITS = 128,
  parameter int GROUP    = 8,
  localparam int GROUPS  = MUX_BITS / GROUP
) (
  input  logic [MUX_BITS-1:0] src,
  input  logic [MUX_BITS-1:0] en,
  output logic [GROUPS-1:0]   grp_hit
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_hit[g] = |(src[g*GROUP +: GROUP] & en[g*GROUP +: GROUP]);
  end
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | set_vec) & ~clr_vec;
  end

  // R8: bits written with 1 are zero after the write edge
  assert_w1c_wins_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(clr_vec)) == '0));

  // R6: set bits not written with 1 survive
  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(pend & ~clr_vec)) == $past(pend & ~clr_vec)));
endmodule

// File: rtl/nmi_wake_ctrl.sv
module nmi_wake_ctrl
  import nmi_wake_pkg::*;
#(
  parameter int TOP_BITS   = 64,
  parameter int MUX_BITS   = 128,
  parameter int GROUP      = 8,
  parameter int NUM_DIRECT = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  nmi_pad,
  input  logic [NUM_DIRECT-1:0] src_direct,
  input  logic [MUX_BITS-1:0]   mux_src,
  output logic                  nmi_irq,
  output logic                  wake_req
);
  localparam int GROUPS    = MUX_BITS / GROUP;
  localparam int MUX_BASE  = NUM_DIRECT + 1;
  localparam int TOP_WORDS = TOP_BITS / 32;
  localparam int MUX_WORDS = MUX_BITS / 32;

  trig_e                trig_q;
  logic [TOP_BITS-1:0]  en_q;
  logic [MUX_BITS-1:0]  mux_en_q;
  logic [TOP_BITS-1:0]  pend;
  logic [TOP_BITS-1:0]  set_vec;
  logic [TOP_BITS-1:0]  clr_vec;
  logic [GROUPS-1:0]    grp_hit;
  logic                 nmi_hit;
  logic [31:0]          rd_next;

  nmi_trigger u_trig (
    .clk (clk),
    .rst (rst),
    .pad (nmi_pad),
    .mode(trig_q),
    .hit (nmi_hit)
  );

  mux_gather #(.MUX_BITS(MUX_BITS), .GROUP(GROUP)) u_mux (
    .src    (mux_src),
    .en     (mux_en_q),
    .grp_hit(grp_hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[0] = nmi_hit;
    set_vec[NUM_DIRECT:1] = src_direct;
    set_vec[MUX_BASE +: GROUPS] = grp_hit;
  end

  always_comb begin
    clr_vec = '0;
    for (int w = 0; w < TOP_WORDS; w++)
      if (bus_wr && bus_addr == 8'(OFS_PEND + 4*w))
        clr_vec[w*32 +: 32] = bus_wdata;
  end

  pend_bank #(.WIDTH(TOP_BITS)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .pend   (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q   <= TRIG_RESET;
      en_q     <= TOP_BITS'(1);
      mux_en_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_TRIG) trig_q <= trig_e'(bus_wdata[1:0]);
      for (int w = 0; w < TOP_WORDS; w++)
        if (bus_addr == 8'(OFS_EN + 4*w)) en_q[w*32 +: 32] <= bus_wdata;
      for (int w = 0; w < MUX_WORDS; w++)
        if (bus_addr == 8'(OFS_MUXEN + 4*w)) mux_en_q[w*32 +: 32] <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == OFS_TRIG) rd_next = {30'd0, trig_q};
    for (int w = 0; w < TOP_WORDS; w++) begin
      if (bus_addr == 8'(OFS_PEND + 4*w)) rd_next = pend[w*32 +: 32];
      if (bus_addr == 8'(OFS_EN + 4*w))   rd_next = en_q[w*32 +: 32];
    end
    for (int w = 0; w < MUX_WORDS; w++)
      if (bus_addr == 8'(OFS_MUXEN + 4*w)) rd_next = mux_en_q[w*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      wake_req  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      wake_req <= |(pend & en_q);
    end
  end

  assign nmi_irq = pend[0];

  // R1: state right after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (en_q == TOP_BITS'(1) && mux_en_q == '0 && pend == '0));

  // R3: an acknowledge always drops the latch at the write edge
  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
    clr_vec[0] |=> !nmi_irq);

  // R4: level-high pad still active after an acknowledge re-sets the latch
  assert_level_reset_R4: assert property (@(posedge clk) disable iff (rst)
    (trig_q == TRIG_LVL_HI && nmi_pad && !clr_vec[0] && !bus_wr) |=> nmi_irq);

  // R5: latched level holds until acknowledged
  assert_nmi_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (nmi_irq && !clr_vec[0]) |=> nmi_irq);

  // R9: no enabled pending bit means no wake request next cycle
  assert_wake_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((pend & en_q) == '0) |=> !wake_req);
endmodule

// File: tb/nmi_wake_ctrl_test.sv
module nmi_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         nmi_pad = 1'b0;
  logic [17:0]  src_direct = '0;
  logic [127:0] mux_src = '0;
  logic         nmi_irq;
  logic         wake_req;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_wake_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_pad(nmi_pad), .src_direct(src_direct), .mux_src(mux_src),
    .nmi_irq(nmi_irq), .wake_req(wake_req)
  );

  // {mode[1:0], pad before, pad after, expected nmi_irq}
  localparam logic [4:0] NMI_VEC [0:7] = '{
    {2'd0, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset state through the register port
    chk("R1 nmi_irq", 32'(nmi_irq), 0);
    chk("R1 wake_req", 32'(wake_req), 0);
    rd(8'h10, d); chk("R1 pend0", d, 0);
    rd(8'h14, d); chk("R1 pend1", d, 0);
    rd(8'h40, d); chk("R1 en0", d, 1);
    rd(8'h44, d); chk("R1 en1", d, 0);
    rd(8'hC0, d); chk("R1 muxen0", d, 0);
    rd(8'hCC, d); chk("R1 muxen3", d, 0);
    rd(8'h0C, d); chk("R1 trig", d, 2);
    rd(8'h20, d); chk("R10 unmapped", d, 0);

    // R2 / R3: trigger vector table
    for (int i = 0; i < 8; i++) begin
      wr(8'h0C, 32'(NMI_VEC[i][4:3]));
      nmi_pad = NMI_VEC[i][2];
      tick(); tick();
      wr(8'h10, 32'h1);
      chk("R3 ack clears", 32'(nmi_irq), 0);
      nmi_pad = NMI_VEC[i][1];
      tick();
      chk("R2 trigger", 32'(nmi_irq), 32'(NMI_VEC[i][0]));
      tick(); tick();
      chk("R3 latch holds", 32'(nmi_irq), 32'(NMI_VEC[i][0]));
    end
    nmi_pad = 1'b0;
    wr(8'h0C, 32'd2);
    wr(8'h10, 32'h1);
    wr(8'h10, 32'h0);
    chk("R3 write zero no effect", 32'(nmi_irq), 0);

    // R5 / R4: NMI independent of enable, level re-set after ack
    wr(8'h40, 32'h0);
    nmi_pad = 1'b1;
    tick();
    chk("R5 nmi without enable", 32'(nmi_irq), 1);
    tick();
    chk("R9 no wake when disabled", 32'(wake_req), 0);
    wr(8'h10, 32'h1);
    chk("R4 cleared at ack edge", 32'(nmi_irq), 0);
    tick();
    chk("R4 set again next edge", 32'(nmi_irq), 1);
    nmi_pad = 1'b0;
    wr(8'h10, 32'h0);
    chk("R3 zero write keeps latch", 32'(nmi_irq), 1);
    wr(8'h10, 32'h1);
    chk("R3 ack after pad idle", 32'(nmi_irq), 0);
    wr(8'h40, 32'h1);

    // R6: direct source bit 17 (src_direct[16])
    @(negedge clk); src_direct[16] = 1'b1;
    @(negedge clk); src_direct[16] = 1'b0;
    tick();
    rd(8'h10, d); chk("R6 direct held", d, 32'h0002_0000);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R8 zero write keeps", d, 32'h0002_0000);
    wr(8'h10, 32'h0002_0000);
    rd(8'h10, d); chk("R8 w1c", d, 0);

    // R7: muxed sources
    mux_src[20] = 1'b1;
    tick(); tick();
    rd(8'h10, d); chk("R7 gated off", d, 0);
    wr(8'hC0, 32'h0010_0000);
    tick();
    rd(8'h10, d); chk("R7 group 2 -> bit 21", d, 32'h0020_0000);
    mux_src[127] = 1'b1;
    wr(8'hCC, 32'h8000_0000);
    tick();
    rd(8'h14, d); chk("R7 group 15 -> bit 34", d, 32'h4);
    rd(8'hCC, d); chk("R7 muxen3 readback", d, 32'h8000_0000);
    mux_src = '0;
    wr(8'h10, 32'h0020_0000);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R10 pend1 clean", d, 0);

    // R8: clear and set in the same cycle
    @(negedge clk); src_direct[2] = 1'b1;
    @(negedge clk); src_direct[2] = 1'b0;
    rd(8'h10, d); chk("R6 bit3 set", d, 32'h8);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h8; src_direct[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; src_direct[2] = 1'b0;
    rd(8'h10, d); chk("R8 clear wins collision", d, 0);
    src_direct[2] = 1'b1;
    wr(8'h10, 32'h8);
    tick();
    rd(8'h10, d); chk("R8 re-set while active", d, 32'h8);
    src_direct[2] = 1'b0;
    wr(8'h10, 32'h8);

    // R9: wake timing on enabled bit 5
    wr(8'h40, 32'h21);
    @(negedge clk); src_direct[4] = 1'b1;
    @(negedge clk); src_direct[4] = 1'b0;
    chk("R9 wake one cycle late", 32'(wake_req), 0);
    tick();
    chk("R9 wake asserted", 32'(wake_req), 1);
    wr(8'h10, 32'h20);
    chk("R9 wake still registered", 32'(wake_req), 1);
    tick();
    chk("R9 wake released", 32'(wake_req), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule